// File: doc/BRIEF.md
# Deferred condition-code evaluator

This block turns a recorded operation into processor condition flags after the fact. The execution unit only stores the class of the last flag-setting operation, its operand size, both operands, the result and, for multiplies, the upper result word. When the flags are needed, a start strobe hands this record to the evaluator. The evaluator derives negative (N), zero (Z), overflow (V), carry (C) and the multiply-step carry (R), then merges them into the current status word.

The merge uses a per-operation update mask. The extended-arithmetic bit X is always part of that mask, so every evaluation clears X. If X was set on entry, a freshly computed Z cannot set a clear Z bit, so zero tests chain across multi-word arithmetic. One operation class marks the status word as already up to date and passes it through unchanged.

The block does no arithmetic of its own. Carry is inferred from the sign bits of the operands and of the result. The new status word appears, with a one-cycle valid pulse, on the clock edge after the strobe.

Top module: `ccflag_eval`

## Requirements
- R1: The status output and a valid pulse are registered on the first clock edge after `start_i`. Without a strobe, `valid_o` is 0 and `status_o` holds its last value. Back-to-back strobes produce back-to-back results.
- R2: Size codes 0, 1 and 2 select 8-, 16- and 32-bit evaluation, and code 3 also selects 32 bits. The sign is taken from bit 7, 15 or 31. Zero covers only the low 8, 16 or 32 result bits.
- R3: Add-type rule (op code 0, and every code from 8 to 15). If the result sign is set, the block sets N, sets V when both operand signs are clear, and sets C when both are set. If the result sign is clear, it sets Z for a zero sized result, sets V when both operand signs are set, and sets C when either is set.
- R4: Subtract (op 1) and compare (op 2) apply the R3 rule to the inverted source and then invert C.
- R5: Multiply-step (op 3) applies the R3 rule at 32 bits whatever the size code. It reports the carry in R (bit 8) and leaves C at 0.
- R6: The logical/move/shift class (op 4) at size code 1, 2 or 3 sets only N (sized sign) or else Z (sized zero). At size code 0 it follows R3.
- R7: Multiplies (op 5 signed, op 6 unsigned) form a 64-bit value {high word, result}. Z is set when the whole value is zero and N when bit 63 is set. C is 0.
- R8: Unsigned multiply sets V when the high word is nonzero. Signed multiply sets V when the high word differs from 32 copies of result bit 31.
- R9: Flag positions are C=0, V=1, Z=2, N=3, X=4 and R=8. Bits in (`mask_i` OR X) take the computed flag, with X always computed as 0. All other status bits pass through unchanged.
- R10: When X is set on entry and the computed Z is 1, Z leaves the write mask and the old Z is kept. A computed Z of 0 is still written when Z is in the mask.
- R11: The live class (op 7) returns `status_i` unchanged, X included.
- R12: Under reset, `valid_o` is 0 and `status_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Evaluate the record presented this cycle |
| op_i | input | 4 | Operation class code |
| size_i | input | 2 | Operand size code |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| res_i | input | 32 | Result (low result word for multiplies) |
| hi_i | input | 32 | High result word of a multiply |
| status_i | input | STAT_W | Current status word |
| mask_i | input | STAT_W | Flag update mask of the operation |
| status_o | output | STAT_W | Updated status word |
| valid_o | output | 1 | One-cycle pulse marking a new status word |

## Verification
The block holds only the output register, so the things that can go wrong are the flag equations and the merge. Either shows up at `status_o` on the cycle after the strobe that exposes it. The vectors are chosen so that every sign combination of each rule flips a distinct flag. They also exercise a byte-zero result whose upper bits are nonzero and the borrow and overflow of compare. They cover multiply values that differ only in the high word and both outcomes of the sticky-Z merge. A stale or wrongly held output register shows up in the idle cycles that follow the table, where `status_o` must not move and `valid_o` must stay low.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

    localparam int WORD_W = 32;
    localparam int WIDE_W = 2 * WORD_W;

    localparam int C_POS = 0;
    localparam int V_POS = 1;
    localparam int Z_POS = 2;
    localparam int N_POS = 3;
    localparam int X_POS = 4;
    localparam int R_POS = 8;
    localparam int MIN_STAT_W = R_POS + 1;

    typedef enum logic [3:0] {
        CC_ADD   = 4'd0,
        CC_SUB   = 4'd1,
        CC_CMP   = 4'd2,
        CC_MSTEP = 4'd3,
        CC_LOGIC = 4'd4,
        CC_MULS  = 4'd5,
        CC_MULU  = 4'd6,
        CC_LIVE  = 4'd7
    } cc_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } cc_size_e;

    typedef struct packed {
        logic r;
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    // Sign bit of a word at the given operand size
    function automatic logic sized_sign(input logic [WORD_W-1:0] w, input logic [1:0] sz);
        logic s;
        case (sz)
            SZ_BYTE: s = w[7];
            SZ_HALF: s = w[15];
            default: s = w[WORD_W-1];
        endcase
        return s;
    endfunction

    // Zero test restricted to the low bits of the given operand size
    function automatic logic sized_zero(input logic [WORD_W-1:0] w, input logic [1:0] sz);
        logic zr;
        case (sz)
            SZ_BYTE: zr = (w[7:0] == 8'd0);
            SZ_HALF: zr = (w[15:0] == 16'd0);
            default: zr = (w == '0);
        endcase
        return zr;
    endfunction

endpackage

// File: rtl/ccflag_arith.sv
module ccflag_arith
    import ccflag_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] dst_i,
    input  logic [WORD_W-1:0] res_i,
    output cc_flags_t         flags_o
);

    logic        is_sub;
    logic        is_mstep;
    logic        is_short_logic;
    logic [1:0]  eff_size;
    logic [WORD_W-1:0] src_eff;
    logic        s_sign;
    logic        d_sign;
    logic        r_sign;
    logic        r_zero;
    logic        carry_raw;
    cc_flags_t   add_flags;
    cc_flags_t   out_flags;

    always_comb begin
        is_sub         = (op_i == CC_SUB) || (op_i == CC_CMP);
        is_mstep       = (op_i == CC_MSTEP);
        is_short_logic = (op_i == CC_LOGIC) && (size_i != SZ_BYTE);
        eff_size       = is_mstep ? SZ_WORD : size_i;
        src_eff        = is_sub ? ~src_i : src_i;

        s_sign = sized_sign(src_eff, eff_size);
        d_sign = sized_sign(dst_i, eff_size);
        r_sign = sized_sign(res_i, eff_size);
        r_zero = sized_zero(res_i, eff_size);

        // Sign-bit inference of overflow and carry
        add_flags = '0;
        if (r_sign) begin
            add_flags.n = 1'b1;
            add_flags.v = ~s_sign & ~d_sign;
            carry_raw   = s_sign & d_sign;
        end else begin
            add_flags.z = r_zero;
            add_flags.v = s_sign & d_sign;
            carry_raw   = s_sign | d_sign;
        end
        add_flags.c = carry_raw ^ is_sub;

        out_flags = add_flags;
        if (is_mstep) begin
            out_flags.r = add_flags.c;
            out_flags.c = 1'b0;
        end
        if (is_short_logic) begin
            out_flags   = '0;
            out_flags.n = r_sign;
            out_flags.z = ~r_sign & r_zero;
        end
    end

    assign flags_o = out_flags;

    // R3
    nz_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({flags_o.n, flags_o.z}));

    // R5
    mstep_no_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == CC_MSTEP) |-> !flags_o.c);

    // R6
    logic_nz_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == CC_LOGIC) && (size_i != SZ_BYTE)) |-> !(flags_o.v || flags_o.c || flags_o.r));

endmodule

// File: rtl/ccflag_mul.sv
module ccflag_mul
    import ccflag_pkg::*;
(
    input  logic              signed_i,
    input  logic [WORD_W-1:0] res_i,
    input  logic [WORD_W-1:0] hi_i,
    output cc_flags_t         flags_o
);

    logic [WIDE_W-1:0] wide;
    logic [WORD_W-1:0] sext;

    always_comb begin
        wide    = {hi_i, res_i};
        sext    = {WORD_W{res_i[WORD_W-1]}};
        flags_o = '0;
        flags_o.z = (wide == '0);
        flags_o.n = wide[WIDE_W-1];
        flags_o.v = signed_i ? (hi_i != sext) : (hi_i != '0);
    end

endmodule

// File: rtl/ccflag_merge.sv
module ccflag_merge
    import ccflag_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  cc_flags_t         flags_i,
    input  logic [STAT_W-1:0] old_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic [STAT_W-1:0] new_o
);

    logic [STAT_W-1:0] flag_word;
    logic [STAT_W-1:0] x_bit;
    logic [STAT_W-1:0] wr_mask;

    always_comb begin
        flag_word        = '0;
        flag_word[C_POS] = flags_i.c;
        flag_word[V_POS] = flags_i.v;
        flag_word[Z_POS] = flags_i.z;
        flag_word[N_POS] = flags_i.n;
        flag_word[R_POS] = flags_i.r;

        x_bit        = '0;
        x_bit[X_POS] = 1'b1;
        wr_mask      = mask_i | x_bit;
        // Chained zero: a new Z of 1 may not set Z while X is active
        if (old_i[X_POS] && flags_i.z) begin
            wr_mask[Z_POS] = 1'b0;
        end

        new_o = (old_i & ~wr_mask) | (flag_word & wr_mask);
    end

endmodule

// File: rtl/ccflag_eval.sv
module ccflag_eval
    import ccflag_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [31:0]       src_i,
    input  logic [31:0]       dst_i,
    input  logic [31:0]       res_i,
    input  logic [31:0]       hi_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic [STAT_W-1:0] status_o,
    output logic              valid_o
);

    typedef struct packed {
        logic              vld;
        logic [STAT_W-1:0] stat;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    cc_flags_t         arith_flags;
    cc_flags_t         mul_flags;
    cc_flags_t         sel_flags;
    logic [STAT_W-1:0] merged;
    logic              is_mul;

    initial begin
        if (STAT_W < MIN_STAT_W) $error("STAT_W must hold the R flag");
    end

    ccflag_arith u_arith (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .op_i    (op_i),
        .size_i  (size_i),
        .src_i   (src_i),
        .dst_i   (dst_i),
        .res_i   (res_i),
        .flags_o (arith_flags)
    );

    ccflag_mul u_mul (
        .signed_i (op_i == CC_MULS),
        .res_i    (res_i),
        .hi_i     (hi_i),
        .flags_o  (mul_flags)
    );

    ccflag_merge #(.STAT_W(STAT_W)) u_merge (
        .flags_i (sel_flags),
        .old_i   (status_i),
        .mask_i  (mask_i),
        .new_o   (merged)
    );

    always_comb begin
        is_mul    = (op_i == CC_MULS) || (op_i == CC_MULU);
        sel_flags = is_mul ? mul_flags : arith_flags;

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (start_i) begin
            st_d.vld  = 1'b1;
            st_d.stat = (op_i == CC_LIVE) ? status_i : merged;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.stat;
    assign valid_o  = st_q.vld;

    // R1
    valid_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> valid_o);

    // R1
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> (!valid_o && $stable(status_o)));

    // R9
    x_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i != CC_LIVE) |=> !status_o[X_POS]);

    // R9
    unmasked_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i != CC_LIVE) |=>
            (((status_o ^ $past(status_i)) & ~$past(mask_i) & ~(STAT_W'(1) << X_POS)) == '0));

    // R10
    sticky_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i != CC_LIVE && status_i[X_POS] && !status_i[Z_POS]) |=> !status_o[Z_POS]);

    // R11
    live_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && op_i == CC_LIVE) |=> (status_o == $past(status_i)));

endmodule

// File: tb/ccflag_eval_test.sv
module ccflag_eval_test;

    localparam int SW = 16;
    localparam int NV = 24;

    typedef struct packed {
        logic [3:0]    req;
        logic [3:0]    op;
        logic [1:0]    sz;
        logic [31:0]   src;
        logic [31:0]   dst;
        logic [31:0]   res;
        logic [31:0]   hi;
        logic [SW-1:0] stat;
        logic [SW-1:0] mask;
        logic [SW-1:0] expv;
    } vec_t;

    // Flags: C=0x1 V=0x2 Z=0x4 N=0x8 X=0x10 R=0x100
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd3,  4'd0, 2'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 16'h0000, 16'h010F, 16'h000A}, // R3 N,V
        '{4'd3,  4'd0, 2'd2, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h0, 16'h0000, 16'h010F, 16'h0005}, // R3 Z,C
        '{4'd3,  4'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h00000000, 32'h0, 16'h0000, 16'h010F, 16'h0007}, // R3 Z,V,C
        '{4'd3,  4'd0, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h0, 16'h0000, 16'h010F, 16'h0009}, // R3 N,C
        '{4'd2,  4'd0, 2'd0, 32'h000000FF, 32'h00000001, 32'h00000100, 32'h0, 16'h0000, 16'h010F, 16'h0005}, // R2 byte zero
        '{4'd2,  4'd0, 2'd1, 32'h00007000, 32'h00001000, 32'h00008000, 32'h0, 16'h0000, 16'h010F, 16'h000A}, // R2 half sign
        '{4'd4,  4'd1, 2'd2, 32'h00000001, 32'h00000001, 32'h00000000, 32'h0, 16'h0000, 16'h010F, 16'h0004}, // R4 equal
        '{4'd4,  4'd1, 2'd2, 32'h00000002, 32'h00000001, 32'hFFFFFFFF, 32'h0, 16'h0000, 16'h010F, 16'h0009}, // R4 borrow
        '{4'd4,  4'd2, 2'd0, 32'h00000001, 32'h00000080, 32'h0000007F, 32'h0, 16'h0000, 16'h010F, 16'h0002}, // R4 cmp overflow
        '{4'd5,  4'd3, 2'd0, 32'h80000000, 32'h80000000, 32'h00000000, 32'h0, 16'h0000, 16'h010F, 16'h0106}, // R5 carry in R
        '{4'd6,  4'd4, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h0, 16'h0000, 16'h010F, 16'h0008}, // R6 N only
        '{4'd6,  4'd4, 2'd1, 32'h0, 32'h0, 32'h00010000, 32'h0, 16'h0000, 16'h010F, 16'h0004},               // R6 half zero
        '{4'd6,  4'd4, 2'd0, 32'h00000080, 32'h00000080, 32'h00000000, 32'h0, 16'h0000, 16'h010F, 16'h0007}, // R6 byte add path
        '{4'd7,  4'd6, 2'd2, 32'h0, 32'h0, 32'h00000000, 32'h00000000, 16'h0000, 16'h010F, 16'h0004},        // R7 zero
        '{4'd8,  4'd6, 2'd2, 32'h0, 32'h0, 32'h00000001, 32'h80000000, 16'h0000, 16'h010F, 16'h000A},        // R8 R7 unsigned
        '{4'd8,  4'd5, 2'd2, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 16'h010F, 16'h0008},        // R8 signed ok
        '{4'd8,  4'd5, 2'd2, 32'h0, 32'h0, 32'h80000000, 32'h00000000, 16'h0000, 16'h010F, 16'h0002},        // R8 signed ovf
        '{4'd9,  4'd5, 2'd2, 32'h0, 32'h0, 32'h00000005, 32'h00000000, 16'h000F, 16'h010F, 16'h0000},        // R9 clear all
        '{4'd9,  4'd0, 2'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 16'hA0F5, 16'h0002, 16'hA0E7}, // R9 narrow mask
        '{4'd10, 4'd0, 2'd2, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h0, 16'h0010, 16'h010F, 16'h0001}, // R10 Z kept 0
        '{4'd10, 4'd0, 2'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 16'h0014, 16'h010F, 16'h000A}, // R10 Z cleared
        '{4'd11, 4'd7, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 16'hBEFF, 16'hFFFF, 16'hBEFF},        // R11 live
        '{4'd3,  4'd15, 2'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h0, 16'h0000, 16'h010F, 16'h000A},// R3 spare code
        '{4'd2,  4'd0, 2'd3, 32'h00000000, 32'h00000000, 32'h00008000, 32'h0, 16'h0000, 16'h010F, 16'h0000}  // R2 code 3 is word
    };

    logic          clk;
    logic          rst_n;
    logic          start;
    logic [3:0]    op;
    logic [1:0]    sz;
    logic [31:0]   src, dst, res, hi;
    logic [SW-1:0] stat, mask;
    logic [SW-1:0] status_o;
    logic          valid_o;

    int n_cmp = 0;
    int n_bad = 0;

    ccflag_eval #(.STAT_W(SW)) uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .op_i     (op),
        .size_i   (sz),
        .src_i    (src),
        .dst_i    (dst),
        .res_i    (res),
        .hi_i     (hi),
        .status_i (stat),
        .mask_i   (mask),
        .status_o (status_o),
        .valid_o  (valid_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(input vec_t v);
        start = 1'b1;
        op    = v.op;
        sz    = v.sz;
        src   = v.src;
        dst   = v.dst;
        res   = v.res;
        hi    = v.hi;
        stat  = v.stat;
        mask  = v.mask;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        start = 1'b0;
        op    = '0;
        sz    = '0;
        src   = '0;
        dst   = '0;
        res   = '0;
        hi    = '0;
        stat  = '0;
        mask  = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 valid in reset", {31'd0, valid_o}, 32'd0);
        check("R12 status in reset", {16'd0, status_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", {31'd0, valid_o}, 32'd0);

        // Table walked back to back: R1 result one edge after each strobe
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R1 valid vec %0d", i), {31'd0, valid_o}, 32'd1);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), {16'd0, status_o}, {16'd0, VECS[i].expv});
        end

        // R1 hold: no strobe, status stays, valid low, inputs changing
        start = 1'b0;
        stat  = 16'h1234;
        op    = 4'd7;
        @(negedge clk);
        check("R1 pulse ends", {31'd0, valid_o}, 32'd0);
        check("R1 hold status", {16'd0, status_o}, {16'd0, VECS[NV-1].expv});
        @(negedge clk);
        check("R1 hold status 2", {16'd0, status_o}, {16'd0, VECS[NV-1].expv});

        // R11 live keeps X set
        drive(VECS[21]);
        stat = 16'h0014;
        @(negedge clk);
        check("R11 live keeps X", {16'd0, status_o}, 32'h0014);

        // R10 X set, old Z set, new Z set: Z stays 1, X cleared
        drive(VECS[1]);
        stat = 16'h0014;
        @(negedge clk);
        check("R10 Z kept 1", {16'd0, status_o}, 32'h0005);

        // R12 reset mid-stream clears the output
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 status after reset", {16'd0, status_o}, 32'd0);
        check("R12 valid after reset", {31'd0, valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule